// File: doc/BRIEF.md
# Bunch-Crossing Pair Multiplexer

This block lets two neighbouring trigger channels share one output link. In every 40 MHz crossing it takes a 10-bit result from each channel and registers one output word. Each word has a channel flag, a 10-bit data field and a parity bit.

Channel results are sparse. A channel that produces a nonzero value is always followed by at least one empty crossing. When a hit appears, the hit value goes out one clock later. In the next crossing, which is otherwise unused, the block sends the other channel's value from the hit crossing. The flag marks the channel: 0 for channel A, 1 for channel B.

A bypass input turns the pairing off. In bypass, the output carries channel A directly. If a new hit arrives while a deferred value is still waiting, the new hit wins, the waiting value is discarded, and a one-cycle collision error is raised.

Top module: `bcx_pair_mux`

## Requirements
- R1: Each output word is a flag (`o_flag`), a 10-bit data field (`o_data`) and a parity bit (`o_par`). The word for an input crossing appears one clock after that crossing is sampled.
- R2: When bypass is off, `o_flag`, `o_data` and `o_par` together always have an odd number of ones.
- R3: If channel A is nonzero in crossing N, the word after N carries A's value with flag 0. The word after N+1 carries B's crossing-N value with flag 1, provided crossing N+1 has no hit.
- R4: If only channel B is nonzero in crossing N, the word after N carries B's value with flag 1. The next word carries A's crossing-N value (zero) with flag 0, provided crossing N+1 has no hit.
- R5: If both channels are nonzero in the same crossing, channel A is sent first with flag 0, and B follows with flag 1 one crossing later.
- R6: If a crossing has a hit while a deferred value is pending, the new hit is sent as in R3 to R5. The deferred value is never sent, and `o_err` is 1 for exactly the word of that crossing. In all other cases `o_err` is 0.
- R7: A crossing with no hit and nothing pending produces data 0, flag 0 and parity 1.
- R8: While `i_bypass` is 1, each word carries A's value, flag 0 and parity equal to bit 0 of A's value. Nothing is deferred, `o_err` stays 0, and any pending value is discarded.
- R9: While `rst_n` is low, the output is the idle word of R7 with `o_err` at 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| i_bypass | input | 1 | 1 disables pairing and passes channel A through |
| i_a | input | 10 | Channel A result for this crossing |
| i_b | input | 10 | Channel B result for this crossing |
| o_flag | output | 1 | Channel flag: 0 for channel A, 1 for channel B |
| o_data | output | 10 | Output data field |
| o_par | output | 1 | Odd parity in normal mode, or A bit 0 in bypass |
| o_err | output | 1 | One-cycle collision pulse |

## Verification
A deferred send and a new primary hit can both claim the same output crossing. The bench provokes this by placing a hit on either channel in the crossing directly after an earlier hit. It also does this back to back, so that collisions chain together. The judgement is that the new value appears with its own flag, the pending value is never seen, and the error pulse comes with exactly that word. Bypass is also switched on while a value is pending, to confirm that the deferred word is dropped without raising an error.

// File: rtl/bcx_pair_mux.sv
module bcx_pair_mux #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_bypass,
  input  logic [DW-1:0] i_a,
  input  logic [DW-1:0] i_b,
  output logic          o_flag,
  output logic [DW-1:0] o_data,
  output logic          o_par,
  output logic          o_err
);

  logic          pend_q, pend_d;
  logic          pflag_q, pflag_d;
  logic [DW-1:0] pdata_q, pdata_d;
  logic          flag_d, par_d, err_d;
  logic [DW-1:0] data_d;

  wire hit_a = |i_a;
  wire hit_b = |i_b;
  wire hit   = hit_a | hit_b;

  always_comb begin
    pend_d  = 1'b0;
    pflag_d = 1'b0;
    pdata_d = '0;
    flag_d  = 1'b0;
    data_d  = '0;
    err_d   = 1'b0;
    if (i_bypass) begin
      data_d = i_a;
    end else if (hit) begin
      err_d   = pend_q;
      pend_d  = 1'b1;
      if (hit_a) begin
        data_d  = i_a;
        pflag_d = 1'b1;
        pdata_d = i_b;
      end else begin
        flag_d  = 1'b1;
        data_d  = i_b;
        pdata_d = i_a;
      end
    end else if (pend_q) begin
      flag_d = pflag_q;
      data_d = pdata_q;
    end
    par_d = i_bypass ? i_a[0] : ~^{flag_d, data_d};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pflag_q <= 1'b0;
      pdata_q <= '0;
      o_flag  <= 1'b0;
      o_data  <= '0;
      o_par   <= 1'b1;
      o_err   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pflag_q <= pflag_d;
      pdata_q <= pdata_d;
      o_flag  <= flag_d;
      o_data  <= data_d;
      o_par   <= par_d;
      o_err   <= err_d;
    end
  end

  assert_odd_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(i_bypass) |-> (^{o_flag, o_data, o_par}) == 1'b1);

  assert_bypass_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(i_bypass) |-> (!o_flag && !o_err && o_data == $past(i_a) && o_par == $past(i_a[0])));

  assert_idle_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!i_bypass && !pend_q && i_a == '0 && i_b == '0) |-> (o_data == '0 && !o_flag && o_par && !o_err));

  assert_deferred_sent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!i_bypass && pend_q && i_a == '0 && i_b == '0) |-> (o_data == $past(pdata_q) && o_flag == $past(pflag_q)));

  assert_primary_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!i_bypass && i_a != '0) |-> (o_data == $past(i_a) && !o_flag && pend_q && pflag_q));

  assert_collision_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    o_err |-> ($past(pend_q) && !$past(i_bypass)));

endmodule

// File: tb/sim_bcx_pair_mux.sv
module sim_bcx_pair_mux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byp = 1'b0;
  logic [9:0] a = '0, b = '0;
  logic       o_flag, o_par, o_err;
  logic [9:0] o_data;

  int total = 0, bad = 0;
  bit done = 1'b0;

  int m_pend = 0, m_pflag = 0, m_pdata = 0;
  int e_flag = 0, e_data = 0, e_par = 1, e_err = 0;

  always #5 clk = ~clk;

  bcx_pair_mux u0 (.clk(clk), .rst_n(rst_n), .i_bypass(byp), .i_a(a), .i_b(b),
                   .o_flag(o_flag), .o_data(o_data), .o_par(o_par), .o_err(o_err));

  function automatic int oddpar(int f, int d);
    int n = f;
    for (int i = 0; i < 10; i++) n += (d >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  task automatic model(int va, int vb, int vbyp);
    e_err = 0;
    if (vbyp != 0) begin
      e_flag = 0; e_data = va; e_par = va & 1; m_pend = 0;
    end else begin
      if (va != 0 || vb != 0) begin
        e_err = m_pend;
        if (va != 0) begin e_flag = 0; e_data = va; m_pflag = 1; m_pdata = vb; end
        else begin e_flag = 1; e_data = vb; m_pflag = 0; m_pdata = va; end
        m_pend = 1;
      end else if (m_pend != 0) begin
        e_flag = m_pflag; e_data = m_pdata; m_pend = 0;
      end else begin
        e_flag = 0; e_data = 0;
      end
      e_par = oddpar(e_flag, e_data);
    end
  endtask

  task automatic compare(string req);
    total++;
    if (o_flag !== e_flag[0] || o_data !== e_data[9:0] || o_par !== e_par[0] || o_err !== e_err[0]) begin
      bad++;
      $display("FAIL %s: got flag=%0b data=%0d par=%0b err=%0b exp flag=%0d data=%0d par=%0d err=%0d",
               req, o_flag, o_data, o_par, o_err, e_flag, e_data, e_par, e_err);
    end
  endtask

  task automatic step(int va, int vb, int vbyp, string req);
    @(negedge clk);
    a = va[9:0]; b = vb[9:0]; byp = vbyp[0];
    @(posedge clk);
    model(va, vb, vbyp);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    e_flag = 0; e_data = 0; e_par = 1; e_err = 0;
    compare("R9 reset");
    rst_n = 1'b1;
    step(0, 0, 0, "R7 idle");
    step(0, 0, 0, "R7 idle");
    step(37, 5, 0, "R3 A primary");
    step(0, 0, 0, "R3 B deferred");
    step(200, 0, 0, "R3 A primary, B zero");
    step(0, 0, 0, "R3 zero deferred flag 1");
    step(0, 513, 0, "R4 B only");
    step(0, 0, 0, "R4 A deferred flag 0");
    step(1023, 1023, 0, "R5 both hit");
    step(0, 0, 0, "R5 B follows");
    step(12, 99, 0, "R6 first hit");
    step(0, 44, 0, "R6 collision on B");
    step(0, 0, 0, "R6 after collision");
    step(7, 0, 0, "R6 chain start");
    step(8, 9, 0, "R6 chain 1");
    step(0, 3, 0, "R6 chain 2");
    step(0, 0, 0, "R6 chain tail");
    step(0, 0, 0, "R7 idle again");
    step(300, 1, 0, "R8 pending before bypass");
    step(0, 0, 1, "R8 bypass drops pending");
    step(301, 77, 1, "R8 bypass odd A");
    step(300, 0, 1, "R8 bypass even A");
    step(0, 0, 0, "R8 leave bypass idle");
    for (int i = 0; i < 400; i++) begin
      int ra = ($urandom % 4 == 0) ? int'($urandom % 1024) : 0;
      int rb = ($urandom % 4 == 0) ? int'($urandom % 1024) : 0;
      int rbyp = ($urandom % 16 == 0) ? 1 : 0;
      step(ra, rb, rbyp, "R2 random mix");
    end
    rst_n = 1'b0;
    @(posedge clk);
    e_flag = 0; e_data = 0; e_par = 1; e_err = 0;
    m_pend = 0;
    @(negedge clk);
    compare("R1 R9 reset again");
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got running exp done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule